// File: doc/BRIEF.md
# Serial Port Register Block with 8N1 Transmitter

This block is the software-facing side of a small serial port. A simple processor bus reaches eight byte-wide registers placed one per 32-bit word: four read-only identity bytes, a data port, a combined status/control byte and the two halves of a 16-bit baud divisor. Writing the data port fills a single-character transmit holding stage. That stage passes its byte to an 8N1 serializer. The serializer holds each line bit for four divisor ticks.

Received bytes come from an external receive FIFO through a show-ahead data bus, three level flags and a pop strobe. Reading the data port returns the FIFO head and pops it. Two sticky error flags record framing and overflow events reported by the receive side. Receive and transmit interrupt causes are gated by their own enable bits and combined onto one interrupt line.

Top module: `uart_regblk`

## Requirements
- R1: The register is chosen by address bits [4:2]. Index 0-3 selects ID bytes 0-3, 4 the data port, 5 status, 6 divisor low byte and 7 divisor high byte. An access with address bits [1:0] not zero, or with any bit above bit 4 set, is ignored: a read returns 0 and pops nothing, a write changes nothing.
- R2: The status byte reads as follows. Bit 7 is transmit holding empty, bit 6 the transmit interrupt enable, bit 5 FIFO empty, bit 4 FIFO has exactly one free slot, bit 3 FIFO full, bit 2 the receive interrupt enable, bit 1 the overflow flag and bit 0 the framing-error flag.
- R3: A data-port write made while status bit 7 is 1 loads the holding stage, and bit 7 reads 0 in the following cycle until the byte moves to the serializer. A data-port write made while bit 7 is 0 is discarded.
- R4: A data-port read returns the FIFO head and pops exactly one entry. A data-port read while the FIFO is empty pops nothing.
- R5: `irq` is 1 exactly when (rx enable and (FIFO not empty or an error flag set)) or (tx enable and holding empty).
- R6: With divisor D (high:low), each transmitted bit lasts exactly 4*(D+1) clock cycles.
- R7: A character is sent as a low start bit, then 8 data bits LSB first, then a high stop bit.
- R8: The error flags are set by a one-cycle pulse on their inputs and stay set. A status write with the flag's bit at 0 clears it, and a write with that bit at 1 leaves it as it was. A set in the same cycle as a clear wins.
- R9: ID byte i reads as bits [8i+7:8i] of parameter `ID_WORD`. Writes to the ID bytes and to status bits 7, 5, 4 and 3 have no effect.
- R10: The line idles high and changes only when a character is loaded or at a bit boundary. A byte waiting in the holding stage starts its start bit one cycle after the previous stop bit ends.
- R11: After reset both enables and both error flags are 0, the divisor is 0, the holding stage is empty, `tx_line` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rxf_data | input | 8 | Head entry of the receive FIFO |
| rxf_empty | input | 1 | Receive FIFO holds no entry |
| rxf_full | input | 1 | Receive FIFO is full |
| rxf_one_free | input | 1 | Receive FIFO has exactly one free slot |
| rxf_pop | output | 1 | Remove the head entry at this clock edge |
| rx_frame_err | input | 1 | One-cycle pulse: stop bit missing |
| rx_overflow | input | 1 | One-cycle pulse: byte lost to a full FIFO |
| tx_line | output | 1 | Serial transmit output |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the following: a pop happens only on a data-port read of a non-empty FIFO; the holding stage fills only after a data-port write; the framing flag drops only after a clearing status write; the line moves only on a load or a baud tick; and the interrupt line follows its enables. Exact bit lengths for several divisors, LSB-first order, the discarded write while the holding stage is full, the one-cycle gap between back-to-back characters, the FIFO order and the read-back of every register can only be shown by the bench's scenarios, which decode the line and model the FIFO.

// File: rtl/uart_regblk_pkg.sv
// Shared definitions for the serial register block: register indices,
// status bit positions and frame constants.
package uart_regblk_pkg;
    localparam int BYTE_W        = 8;
    localparam int DIV_W         = 2 * BYTE_W;
    localparam int TICKS_PER_BIT = 4;
    localparam int FRAME_BITS    = BYTE_W + 2;

    typedef enum logic [2:0] {
        IDX_ID0   = 3'd0,
        IDX_ID1   = 3'd1,
        IDX_ID2   = 3'd2,
        IDX_ID3   = 3'd3,
        IDX_DATA  = 3'd4,
        IDX_STAT  = 3'd5,
        IDX_DIVLO = 3'd6,
        IDX_DIVHI = 3'd7
    } reg_idx_e;

    localparam int ST_FERR    = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_RXIE    = 2;
    localparam int ST_RXFULL  = 3;
    localparam int ST_RXONE   = 4;
    localparam int ST_RXEMPTY = 5;
    localparam int ST_TXIE    = 6;
    localparam int ST_TXEMPTY = 7;
endpackage

// File: rtl/uart_baud_gen.sv
// Baud tick generator. While enabled it emits one tick every DIV+1 cycles;
// while disabled the count is held at zero so that the first tick comes
// exactly DIV+1 cycles after enable rises. Assumes div is stable during use.
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Count cycles within one tick period, restarting at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
// 8N1 serializer. Accepts a byte on load when idle, then shifts out the
// start bit, the data LSB first and the stop bit, each lasting TICKS ticks.
// Assumes load is only raised when busy is low.
module uart_tx_shift #(
    parameter int DATA_W = 8,
    parameter int TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] ldata,
    output logic              busy,
    output logic              line
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int BCNT_W  = $clog2(FRAME_W);
    localparam int SUB_W   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_W - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB = SUB_W'(TICKS - 1);

    logic [FRAME_W-1:0] shreg;
    logic [BCNT_W-1:0]  bitcnt;
    logic [SUB_W-1:0]   sub;

    assign line = busy ? shreg[0] : 1'b1;

    // Load a frame, count ticks within a bit and advance at bit boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shreg  <= '1;
            bitcnt <= '0;
            sub    <= '0;
        end else if (load && !busy) begin
            busy   <= 1'b1;
            shreg  <= {1'b1, ldata, 1'b0};
            bitcnt <= '0;
            sub    <= '0;
        end else if (busy && tick) begin
            if (sub == LAST_SUB) begin
                sub   <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                if (bitcnt == LAST_BIT) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_regblk.sv
// Register block of the serial port. Decodes eight byte registers, one per
// word, drives a one-character transmit holding stage into the serializer,
// reads and pops the external receive FIFO, keeps sticky error flags and
// merges receive and transmit interrupt causes onto one line.
// Assumes the FIFO presents its head entry on rxf_data (show-ahead).
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int          ADDR_W  = 5,
    parameter logic [31:0] ID_WORD = 32'h5A31_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] rxf_data,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic              rxf_one_free,
    output logic              rxf_pop,
    input  logic              rx_frame_err,
    input  logic              rx_overflow,
    output logic              tx_line,
    output logic              irq
);
    logic              hit;
    reg_idx_e          idx;
    logic              wr_acc, rd_acc;
    logic              hold_full, hold_load, ser_load, ser_busy, bit_tick;
    logic [BYTE_W-1:0] hold_data;
    logic              rx_ie, tx_ie, ferr, ovf;
    logic [DIV_W-1:0]  div_q;
    logic              stat_wr;
    logic [BYTE_W-1:0] status;

    assign hit       = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
    assign idx       = reg_idx_e'(bus_addr[4:2]);
    assign wr_acc    = bus_sel && bus_wr && hit;
    assign rd_acc    = bus_sel && !bus_wr && hit;
    assign stat_wr   = wr_acc && (idx == IDX_STAT);
    assign hold_load = wr_acc && (idx == IDX_DATA) && !hold_full;
    assign ser_load  = hold_full && !ser_busy;
    assign rxf_pop   = rd_acc && (idx == IDX_DATA) && !rxf_empty;

    // Single-character transmit holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (hold_load) begin
            hold_full <= 1'b1;
            hold_data <= bus_wdata;
        end else if (ser_load) begin
            hold_full <= 1'b0;
        end
    end

    // Interrupt enables and sticky error flags (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
            ferr  <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (stat_wr) begin
                rx_ie <= bus_wdata[ST_RXIE];
                tx_ie <= bus_wdata[ST_TXIE];
            end
            ferr <= rx_frame_err || (ferr && !(stat_wr && !bus_wdata[ST_FERR]));
            ovf  <= rx_overflow  || (ovf  && !(stat_wr && !bus_wdata[ST_OVF]));
        end
    end

    // Baud divisor bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_acc && idx == IDX_DIVLO) begin
            div_q[BYTE_W-1:0] <= bus_wdata;
        end else if (wr_acc && idx == IDX_DIVHI) begin
            div_q[DIV_W-1:BYTE_W] <= bus_wdata;
        end
    end

    // Assemble the status byte from flags, enables and FIFO levels.
    always_comb begin
        status             = '0;
        status[ST_FERR]    = ferr;
        status[ST_OVF]     = ovf;
        status[ST_RXIE]    = rx_ie;
        status[ST_RXFULL]  = rxf_full;
        status[ST_RXONE]   = rxf_one_free;
        status[ST_RXEMPTY] = rxf_empty;
        status[ST_TXIE]    = tx_ie;
        status[ST_TXEMPTY] = !hold_full;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (idx)
                IDX_ID0:   bus_rdata = ID_WORD[7:0];
                IDX_ID1:   bus_rdata = ID_WORD[15:8];
                IDX_ID2:   bus_rdata = ID_WORD[23:16];
                IDX_ID3:   bus_rdata = ID_WORD[31:24];
                IDX_DATA:  bus_rdata = rxf_data;
                IDX_STAT:  bus_rdata = status;
                IDX_DIVLO: bus_rdata = div_q[BYTE_W-1:0];
                IDX_DIVHI: bus_rdata = div_q[DIV_W-1:BYTE_W];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_ie && (!rxf_empty || ferr || ovf)) || (tx_ie && !hold_full);

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ser_busy),
        .div  (div_q),
        .tick (bit_tick)
    );

    uart_tx_shift #(.DATA_W(BYTE_W), .TICKS(TICKS_PER_BIT)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (bit_tick),
        .load (ser_load),
        .ldata(hold_data),
        .busy (ser_busy),
        .line (tx_line)
    );
endmodule

// File: rtl/uart_regblk_chk.sv
// Property checker for uart_regblk, attached by bind below. Observes ports
// and a few internal handshake signals; drives nothing.
module uart_regblk_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rxf_empty,
    input logic              rxf_pop,
    input logic              tx_line,
    input logic              irq,
    input logic              hold_full,
    input logic              ser_load,
    input logic              bit_tick,
    input logic              rx_ie,
    input logic              tx_ie,
    input logic              ferr,
    input logic              rx_frame_err
);
    // R4
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> (!rxf_empty && bus_sel && !bus_wr && bus_addr[4:2] == 3'd4));

    // R3
    hold_fill_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_full) |-> $past(bus_sel && bus_wr && bus_addr[4:2] == 3'd4));

    // R8
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ferr)) |-> $past(bus_sel && bus_wr && bus_addr[4:2] == 3'd5
                                && !bus_wdata[0] && !rx_frame_err));

    // R10
    line_moves_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_line) |-> ($past(ser_load) || $past(bit_tick)));

    // R5
    irq_tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && !hold_full) |-> irq);

    // R5
    irq_rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && !rxf_empty) |-> irq);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind uart_regblk uart_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rxf_empty   (rxf_empty),
    .rxf_pop     (rxf_pop),
    .tx_line     (tx_line),
    .irq         (irq),
    .hold_full   (hold_full),
    .ser_load    (ser_load),
    .bit_tick    (bit_tick),
    .rx_ie       (rx_ie),
    .tx_ie       (tx_ie),
    .ferr        (ferr),
    .rx_frame_err(rx_frame_err)
);

// File: tb/sim_uart_regblk.sv
`timescale 1ns/1ps
module sim_uart_regblk;
    localparam logic [31:0] ID = 32'hC3A5_1E77;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rxf_data;
    logic       rxf_empty, rxf_full, rxf_one_free, rxf_pop;
    logic       rx_frame_err = 1'b0, rx_overflow = 1'b0;
    logic       tx_line, irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, pops = 0;
    bit done = 0;

    // bench model of the receive FIFO (depth 4)
    logic [7:0] fq [4];
    int fcnt = 0;
    assign rxf_data     = fq[0];
    assign rxf_empty    = (fcnt == 0);
    assign rxf_full     = (fcnt == 4);
    assign rxf_one_free = (fcnt == 3);

    // transmit monitor state
    int      cur_b = 4;
    logic [7:0] expq [$];
    int      frames = 0;
    int      start_cyc [$];

    always #2.5 clk = ~clk;

    uart_regblk #(.ADDR_W(5), .ID_WORD(ID)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxf_data(rxf_data), .rxf_empty(rxf_empty), .rxf_full(rxf_full),
        .rxf_one_free(rxf_one_free), .rxf_pop(rxf_pop),
        .rx_frame_err(rx_frame_err), .rx_overflow(rx_overflow),
        .tx_line(tx_line), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input bit txe, input bit txie,
                                              input int cnt, input bit rxie,
                                              input bit ov, input bit fe);
        return {txe, txie, cnt == 0, cnt == 3, cnt == 4, rxie, ov, fe};
    endfunction

    // cycle counter, FIFO pops and watchdog
    always @(posedge clk) begin
        cyc++;
        if (rxf_pop && fcnt > 0) begin
            pops++;
            for (int i = 0; i < 3; i++) fq[i] = fq[i+1];
            fcnt--;
        end
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic fifo_push(input logic [7:0] v);
        @(negedge clk);
        fq[fcnt] = v;
        fcnt++;
    endtask

    task automatic wait_tx_room();
        logic [7:0] s;
        s = 8'h00;
        while (!s[7]) bus_read(5'd20, s);
    endtask

    task automatic set_div(input logic [15:0] d);
        bus_write(5'd24, d[7:0]);
        bus_write(5'd28, d[15:8]);
        cur_b = 4 * (int'(d) + 1);
    endtask

    task automatic wait_frames(input int n);
        int t;
        t = 0;
        while (frames < n && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    // line monitor: decodes frames, compares every sample with the expected bit
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_line === 1'b0) begin
                logic [9:0] ebits;
                logic [7:0] ed;
                int bad;
                int b;
                b = cur_b;
                bad = 0;
                start_cyc.push_back(cyc);
                if (expq.size() == 0) begin
                    ed = 8'h00;
                    bad = 1;
                end else begin
                    ed = expq.pop_front();
                end
                ebits = {1'b1, ed, 1'b0};
                for (int i = 0; i < 10 * b; i++) begin
                    if (i > 0) @(negedge clk);
                    if (tx_line !== ebits[i / b]) bad++;
                end
                // R6 R7: each bit held exactly 4*(D+1) cycles, start/LSB-first/stop
                check(bad == 0, "R6/R7 frame", bad, 0);
                frames++;
            end
        end
    end

    initial begin
        logic [7:0] v, s, a, bb;
        int n;
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 4; i++) fq[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        bus_read(5'd20, s);
        check(s == exp_status(1, 0, 0, 0, 0, 0), "R11 status", s, exp_status(1, 0, 0, 0, 0, 0));
        bus_read(5'd24, v);
        bus_read(5'd28, s);
        check({s, v} == 16'h0, "R11 divisor", {s, v}, 0);
        check(irq == 0 && tx_line == 1, "R11 irq/line", {irq, tx_line}, 1);

        // R9 ID bytes and write protection; R1 decode
        for (int i = 0; i < 4; i++) begin
            bus_write(5'(4 * i), 8'hFF);
            bus_read(5'(4 * i), v);
            check(v == ID[8*i +: 8], "R9 id byte", v, ID[8*i +: 8]);
        end
        bus_write(5'd26, 8'h77);          // unaligned: R1 ignored
        bus_read(5'd24, v);
        check(v == 8'h00, "R1 unaligned write", v, 0);
        bus_read(5'd21, v);
        check(v == 8'h00, "R1 unaligned read", v, 0);

        // R6 divisor read-back
        bus_write(5'd24, 8'h5A);
        bus_write(5'd28, 8'hC3);
        bus_read(5'd24, v);
        bus_read(5'd28, s);
        check({s, v} == 16'hC35A, "R6 divisor rw", {s, v}, 16'hC35A);
        set_div(16'd0);

        // R2 R9 status write: read-only bits ignored
        bus_write(5'd20, 8'hFF);
        bus_read(5'd20, s);
        check(s == exp_status(1, 1, 0, 1, 0, 0), "R9 status ro bits", s, exp_status(1, 1, 0, 1, 0, 0));
        check(irq == 1, "R5 tx irq", irq, 1);
        bus_write(5'd20, 8'h00);
        bus_read(5'd20, s);
        check(s == 8'hA0 && irq == 0, "R2 status clear", s, 8'hA0);

        // R8 framing flag
        @(negedge clk) rx_frame_err = 1;
        @(negedge clk) rx_frame_err = 0;
        bus_read(5'd20, s);
        check(s == 8'hA1 && irq == 0, "R8 ferr set", s, 8'hA1);
        bus_write(5'd20, 8'h05);
        bus_read(5'd20, s);
        check(s == 8'hA5, "R8 ferr kept by write 1", s, 8'hA5);
        check(irq == 1, "R5 rx error irq", irq, 1);
        bus_write(5'd20, 8'h04);
        bus_read(5'd20, s);
        check(s == 8'hA4 && irq == 0, "R8 ferr cleared", s, 8'hA4);
        // overflow flag
        @(negedge clk) rx_overflow = 1;
        @(negedge clk) rx_overflow = 0;
        bus_read(5'd20, s);
        check(s == 8'hA6, "R8 ovf set", s, 8'hA6);
        bus_write(5'd20, 8'h04);
        bus_read(5'd20, s);
        check(s == 8'hA4, "R8 ovf cleared", s, 8'hA4);
        fifo_push(8'h3C);
        #1 check(irq == 1, "R5 rx data irq", irq, 1);
        bus_read(5'd16, v);
        check(v == 8'h3C, "R4 single read", v, 8'h3C);
        bus_write(5'd20, 8'h00);

        // R4 R2 random FIFO contents
        for (int it = 0; it < 20; it++) begin
            logic [7:0] model [4];
            n = $urandom % 5;
            for (int k = 0; k < n; k++) begin
                model[k] = 8'($urandom);
                fifo_push(model[k]);
            end
            bus_read(5'd20, s);
            check(s == exp_status(1, 0, n, 0, 0, 0), "R2 fifo flags", s, exp_status(1, 0, n, 0, 0, 0));
            for (int k = 0; k < n; k++) begin
                bus_read(5'd16, v);
                check(v == model[k], "R4 fifo order", v, model[k]);
            end
            n = pops;
            bus_read(5'd16, v);
            check(pops == n && fcnt == 0, "R4 empty read no pop", pops, n);
        end

        // R3 R10 back-to-back, then dropped write
        set_div(16'd0);
        a = 8'($urandom); bb = 8'($urandom);
        wait_tx_room();
        expq.push_back(a);
        bus_write(5'd16, a);
        bus_read(5'd20, s);
        check(s[7] == 0, "R3 tx empty cleared", s[7], 0);
        wait_tx_room();
        expq.push_back(bb);
        bus_write(5'd16, bb);
        bus_read(5'd20, s);
        check(s[7] == 0, "R3 holding occupied", s[7], 0);
        bus_write(5'd16, 8'hEE);           // must be discarded
        wait_frames(2);
        check(frames == 2 && expq.size() == 0, "R3 dropped write", frames, 2);
        check(start_cyc.size() == 2 && start_cyc[1] - start_cyc[0] == 10 * cur_b + 1,
              "R10 back-to-back gap", start_cyc[1] - start_cyc[0], 10 * cur_b + 1);

        // R6 R7 random bytes and divisors
        for (int it = 0; it < 8; it++) begin
            set_div(16'($urandom % 3));
            v = 8'($urandom);
            wait_tx_room();
            expq.push_back(v);
            bus_write(5'd16, v);
            wait_frames(3 + it);
        end
        check(frames == 10, "R7 frame count", frames, 10);
        check(tx_line == 1, "R10 idle high", tx_line, 1);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule